// File: doc/BRIEF.md
# Paged PHY Register File

This block holds the configuration and status bytes of a serial-bus cable PHY. A link-side controller reaches them through a plain 4-bit address, 8-bit data port. Writes take effect on the clock edge where `wr_en_i` is high. A read is requested with `rd_en_i` and answered one cycle later on `rdata_o`, marked by `rvalid_o`. Addresses 0 to 7 are fixed registers:

- node identity and cable power state;
- bus-reset commands and gap count;
- constant capability bytes;
- self-ID control fields;
- an event/enable byte;
- a page/port selector.

Addresses 8 to 15 form a window. The page number and port number written into address 7 decide what the window shows. Page 0 shows the line state, connection state and per-port control of one of the cable ports. Page 1 shows constant identification bytes.

The block also keeps the sticky event flags: loop, power fail, timeout, port event and per-port fault. Status inputs set these flags and a write of one clears them. Two command bits each pulse for one cycle and clear themselves. The port-event flag gathers changes on ports whose interrupt enable is set, and resume starts while resume interrupts are enabled.

Top module: `phy_regfile`

## Requirements
- R1: After reset, address 1 reads 0x3F (gap count all ones), address 4 reads 0x80 (link active set), and addresses 5 and 7 read 0x00.
- R2: Address 2 always reads 0xE3 (bits 7:5 = 7, bits 4:0 = port count 3). Address 3 reads 0x40 (bits 7:5 = speed code 3'b010, delay 0). Address 6 reads 0x00.
- R3: Writing address 1 with bit 6 set drives `ibr_o` high for exactly the one cycle after the write, and bit 6 then reads 0. Writing address 5 with bit 6 set does the same on `isbr_o`.
- R4: The event bits at address 5 are loop (bit 5), power fail (bit 4), timeout (bit 3) and port event (bit 2). They, and fault (page 0, address 9, bit 3), are cleared by writing a one to them and left unchanged by writing a zero.
- R5: Address 0 reads {node_id[5:0], root, PS}, where PS is `cable_pwr_i` delayed one cycle. Power fail is set in the cycle PS goes from 1 to 0.
- R6: Port event is set when connected, bias, disabled or fault changes on a port whose int_enable (page 0, address 9, bit 4) is 1. It is not set for such changes while int_enable is 0.
- R7: Port event is set when `resume_start_i` pulses for any port while resume_int (address 5, bit 7) is 1, and not while it is 0.
- R8: `link_bit_o` equals link_active (address 4, bit 7) AND `lps_i`.
- R9: Address 7 holds the page in bits 7:5 and the port in bits 3:0; bit 4 reads 0. Page 0 for a port below 3 reads address 8 as {astat[1:0], bstat[1:0], child, connected, bias, disabled}, with line codes 00 invalid, 01 one, 10 zero, 11 Z. It reads address 9 as {speed[2:0], int_enable, fault, 000}. Address 8 bit 0 drives that port's `port_disable_o` bit.
- R10: Page 1 reads address 8 = 0x01 (compliance level), address 9 = 0x00, addresses 10 to 12 = the vendor ID, and addresses 13 to 15 = the product ID, most significant byte first.
- R11: Reads of reserved bits and addresses return 0: window addresses 10 to 15 on page 0, pages 2 to 7, and ports 3 and above. Writes to them change nothing.
- R12: When an event bit is set by hardware and cleared by a write in the same cycle, the bit ends set.
- R13: `rvalid_o` is high exactly one cycle after `rd_en_i`, and `rdata_o` then holds the value of the addressed register before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read request |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid |
| node_id_i | input | 6 | Node address from self-identification |
| is_root_i | input | 1 | Node is root |
| cable_pwr_i | input | 1 | Cable power present |
| lps_i | input | 1 | Link power status |
| loop_set_i | input | 1 | Loop detected event |
| timeout_set_i | input | 1 | Arbitration timeout event |
| astat_i | input | 2*NPORTS | TPA line state per port |
| bstat_i | input | 2*NPORTS | TPB line state per port |
| child_i | input | NPORTS | Port is a child |
| connected_i | input | NPORTS | Port connected (filtered) |
| bias_i | input | NPORTS | Bias detected (filtered) |
| nspeed_i | input | 3*NPORTS | Negotiated speed per port |
| fault_set_i | input | NPORTS | Suspend/resume fault event per port |
| resume_start_i | input | NPORTS | Resume started on port |
| ibr_o | output | 1 | Immediate bus reset command pulse |
| isbr_o | output | 1 | Arbitrated short bus reset command pulse |
| root_hold_o | output | 1 | Root hold-off request |
| gap_count_o | output | 6 | Gap count setting |
| link_bit_o | output | 1 | L bit for self-ID |
| contender_o | output | 1 | Contender bit for self-ID |
| pwr_class_o | output | 3 | Power class for self-ID |
| enab_accel_o | output | 1 | Arbitration acceleration enable |
| enab_multi_o | output | 1 | Multi-speed concatenation enable |
| port_disable_o | output | NPORTS | Per-port disable |
| port_event_o | output | 1 | Port event flag (interrupt) |

## Verification
A hardware event and a software clear of the same event bit can land on the same edge. The bench holds `timeout_set_i` high during the very cycle it writes a one to the timeout bit. A following read must show the bit still set, and only a later write alone clears it. A port change can also arrive together with the write that clears the fault bit. Clearing fault on a port with int_enable set is itself a change, so the bench expects port event to be set again right after that clear.

// File: rtl/phy_regfile_pkg.sv
package phy_regfile_pkg;
  typedef enum logic [3:0] {
    A_IDENT = 4'd0, A_CTRL = 4'd1, A_CAPS = 4'd2, A_SPEED = 4'd3,
    A_NODE  = 4'd4, A_EVT  = 4'd5, A_RSVD = 4'd6, A_PAGE  = 4'd7,
    A_WIN0  = 4'd8, A_WIN1 = 4'd9
  } reg_addr_e;

  localparam logic [2:0] PG_PORT  = 3'd0;
  localparam logic [2:0] PG_IDENT = 3'd1;

  localparam logic [7:0] CAPS_BYTE  = {3'd7, 5'd3};
  localparam logic [7:0] SPEED_BYTE = {3'b010, 1'b0, 4'd0};
  localparam logic [7:0] COMPLY_LVL = 8'h01;

  function automatic logic [7:0] id_byte(input logic [23:0] id, input int unsigned idx);
    return id[23-8*idx -: 8];
  endfunction
endpackage

// File: rtl/phy_base_regs.sv
module phy_base_regs
  import phy_regfile_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [3:0] addr_i,
  input  logic [7:0] wdata_i,
  input  logic       cable_pwr_i,
  input  logic       loop_set_i,
  input  logic       timeout_set_i,
  input  logic       port_evt_i,
  input  logic       resume_any_i,
  output logic       ps_o,
  output logic       rhb_o,
  output logic       ibr_o,
  output logic [5:0] gap_o,
  output logic       link_active_o,
  output logic       contender_o,
  output logic [2:0] pwr_class_o,
  output logic       resume_int_o,
  output logic       isbr_o,
  output logic       loop_o,
  output logic       pwr_fail_o,
  output logic       timeout_o,
  output logic       port_event_o,
  output logic       accel_o,
  output logic       multi_o,
  output logic [2:0] page_o,
  output logic [3:0] port_sel_o
);
  logic wr_ctrl, wr_node, wr_evt, wr_page;
  logic pf_set, pe_set;

  assign wr_ctrl = wr_en_i && (addr_i == A_CTRL);
  assign wr_node = wr_en_i && (addr_i == A_NODE);
  assign wr_evt  = wr_en_i && (addr_i == A_EVT);
  assign wr_page = wr_en_i && (addr_i == A_PAGE);

  assign pf_set = ps_o && !cable_pwr_i;
  assign pe_set = port_evt_i || (resume_int_o && resume_any_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ps_o          <= 1'b0;
      rhb_o         <= 1'b0;
      ibr_o         <= 1'b0;
      gap_o         <= 6'h3F;
      link_active_o <= 1'b1;
      contender_o   <= 1'b0;
      pwr_class_o   <= 3'd0;
      resume_int_o  <= 1'b0;
      isbr_o        <= 1'b0;
      loop_o        <= 1'b0;
      pwr_fail_o    <= 1'b0;
      timeout_o     <= 1'b0;
      port_event_o  <= 1'b0;
      accel_o       <= 1'b0;
      multi_o       <= 1'b0;
      page_o        <= 3'd0;
      port_sel_o    <= 4'd0;
    end else begin
      ps_o   <= cable_pwr_i;
      ibr_o  <= wr_ctrl && wdata_i[6];
      isbr_o <= wr_evt && wdata_i[6];
      if (wr_ctrl) begin
        rhb_o <= wdata_i[7];
        gap_o <= wdata_i[5:0];
      end
      if (wr_node) begin
        link_active_o <= wdata_i[7];
        contender_o   <= wdata_i[6];
        pwr_class_o   <= wdata_i[2:0];
      end
      if (wr_evt) begin
        resume_int_o <= wdata_i[7];
        accel_o      <= wdata_i[1];
        multi_o      <= wdata_i[0];
      end
      // set has priority over write-one-to-clear
      loop_o       <= (loop_o       && !(wr_evt && wdata_i[5])) || loop_set_i;
      pwr_fail_o   <= (pwr_fail_o   && !(wr_evt && wdata_i[4])) || pf_set;
      timeout_o    <= (timeout_o    && !(wr_evt && wdata_i[3])) || timeout_set_i;
      port_event_o <= (port_event_o && !(wr_evt && wdata_i[2])) || pe_set;
      if (wr_page) begin
        page_o     <= wdata_i[7:5];
        port_sel_o <= wdata_i[3:0];
      end
    end
  end
endmodule

// File: rtl/phy_port_slot.sv
module phy_port_slot (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_stat_i,
  input  logic wr_ctrl_i,
  input  logic dis_bit_i,
  input  logic int_en_bit_i,
  input  logic fault_clr_bit_i,
  input  logic connected_i,
  input  logic bias_i,
  input  logic fault_set_i,
  output logic conn_o,
  output logic bias_o,
  output logic dis_o,
  output logic int_en_o,
  output logic fault_o,
  output logic event_o
);
  logic dis_d, fault_d;

  assign dis_d   = wr_stat_i ? dis_bit_i : dis_o;
  assign fault_d = (fault_o && !(wr_ctrl_i && fault_clr_bit_i)) || fault_set_i;
  assign event_o = int_en_o && ((connected_i ^ conn_o) || (bias_i ^ bias_o) ||
                                (dis_d ^ dis_o) || (fault_d ^ fault_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conn_o   <= 1'b0;
      bias_o   <= 1'b0;
      dis_o    <= 1'b0;
      int_en_o <= 1'b0;
      fault_o  <= 1'b0;
    end else begin
      conn_o  <= connected_i;
      bias_o  <= bias_i;
      dis_o   <= dis_d;
      fault_o <= fault_d;
      if (wr_ctrl_i) int_en_o <= int_en_bit_i;
    end
  end
endmodule

// File: rtl/phy_regfile.sv
module phy_regfile
  import phy_regfile_pkg::*;
#(
  parameter int unsigned NPORTS     = 3,
  parameter logic [23:0] VENDOR_ID  = 24'h123456,
  parameter logic [23:0] PRODUCT_ID = 24'hA55AC3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic                  rd_en_i,
  input  logic [3:0]            addr_i,
  input  logic [7:0]            wdata_i,
  output logic [7:0]            rdata_o,
  output logic                  rvalid_o,
  input  logic [5:0]            node_id_i,
  input  logic                  is_root_i,
  input  logic                  cable_pwr_i,
  input  logic                  lps_i,
  input  logic                  loop_set_i,
  input  logic                  timeout_set_i,
  input  logic [2*NPORTS-1:0]   astat_i,
  input  logic [2*NPORTS-1:0]   bstat_i,
  input  logic [NPORTS-1:0]     child_i,
  input  logic [NPORTS-1:0]     connected_i,
  input  logic [NPORTS-1:0]     bias_i,
  input  logic [3*NPORTS-1:0]   nspeed_i,
  input  logic [NPORTS-1:0]     fault_set_i,
  input  logic [NPORTS-1:0]     resume_start_i,
  output logic                  ibr_o,
  output logic                  isbr_o,
  output logic                  root_hold_o,
  output logic [5:0]            gap_count_o,
  output logic                  link_bit_o,
  output logic                  contender_o,
  output logic [2:0]            pwr_class_o,
  output logic                  enab_accel_o,
  output logic                  enab_multi_o,
  output logic [NPORTS-1:0]     port_disable_o,
  output logic                  port_event_o
);
  logic       ps_q, link_active, resume_int, loop_q, pwr_fail_q, timeout_q;
  logic [2:0] page_q;
  logic [3:0] port_sel_q;
  logic [NPORTS-1:0] conn_v, bias_v, int_en_v, fault_v, slot_evt;
  logic       port_evt_set;
  logic [7:0] rd_mux;

  assign port_evt_set = (|slot_evt) || (resume_int && (|resume_start_i));

  phy_base_regs u_base (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .cable_pwr_i,
    .loop_set_i, .timeout_set_i,
    .port_evt_i    (|slot_evt),
    .resume_any_i  (|resume_start_i),
    .ps_o          (ps_q),
    .rhb_o         (root_hold_o),
    .ibr_o         (ibr_o),
    .gap_o         (gap_count_o),
    .link_active_o (link_active),
    .contender_o   (contender_o),
    .pwr_class_o   (pwr_class_o),
    .resume_int_o  (resume_int),
    .isbr_o        (isbr_o),
    .loop_o        (loop_q),
    .pwr_fail_o    (pwr_fail_q),
    .timeout_o     (timeout_q),
    .port_event_o  (port_event_o),
    .accel_o       (enab_accel_o),
    .multi_o       (enab_multi_o),
    .page_o        (page_q),
    .port_sel_o    (port_sel_q)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_slot
    logic sel;
    assign sel = wr_en_i && (page_q == PG_PORT) && (port_sel_q == 4'(p));
    phy_port_slot u_slot (
      .clk_i, .rst_ni,
      .wr_stat_i       (sel && (addr_i == A_WIN0)),
      .wr_ctrl_i       (sel && (addr_i == A_WIN1)),
      .dis_bit_i       (wdata_i[0]),
      .int_en_bit_i    (wdata_i[4]),
      .fault_clr_bit_i (wdata_i[3]),
      .connected_i     (connected_i[p]),
      .bias_i          (bias_i[p]),
      .fault_set_i     (fault_set_i[p]),
      .conn_o          (conn_v[p]),
      .bias_o          (bias_v[p]),
      .dis_o           (port_disable_o[p]),
      .int_en_o        (int_en_v[p]),
      .fault_o         (fault_v[p]),
      .event_o         (slot_evt[p])
    );
  end

  assign link_bit_o = link_active && lps_i;

  always_comb begin
    rd_mux = 8'h00;
    unique case (addr_i)
      A_IDENT: rd_mux = {node_id_i, is_root_i, ps_q};
      A_CTRL:  rd_mux = {root_hold_o, ibr_o, gap_count_o};
      A_CAPS:  rd_mux = CAPS_BYTE;
      A_SPEED: rd_mux = SPEED_BYTE;
      A_NODE:  rd_mux = {link_active, contender_o, 3'd0, pwr_class_o};
      A_EVT:   rd_mux = {resume_int, isbr_o, loop_q, pwr_fail_q, timeout_q,
                         port_event_o, enab_accel_o, enab_multi_o};
      A_RSVD:  rd_mux = 8'h00;
      A_PAGE:  rd_mux = {page_q, 1'b0, port_sel_q};
      default: begin
        if (page_q == PG_IDENT) begin
          case (addr_i)
            4'd8:  rd_mux = COMPLY_LVL;
            4'd10: rd_mux = id_byte(VENDOR_ID, 0);
            4'd11: rd_mux = id_byte(VENDOR_ID, 1);
            4'd12: rd_mux = id_byte(VENDOR_ID, 2);
            4'd13: rd_mux = id_byte(PRODUCT_ID, 0);
            4'd14: rd_mux = id_byte(PRODUCT_ID, 1);
            4'd15: rd_mux = id_byte(PRODUCT_ID, 2);
            default: rd_mux = 8'h00;
          endcase
        end else if (page_q == PG_PORT) begin
          for (int p = 0; p < NPORTS; p++) begin
            if (port_sel_q == 4'(p)) begin
              if (addr_i == A_WIN0)
                rd_mux = {astat_i[2*p +: 2], bstat_i[2*p +: 2], child_i[p],
                          conn_v[p], bias_v[p], port_disable_o[p]};
              else if (addr_i == A_WIN1)
                rd_mux = {nspeed_i[3*p +: 3], int_en_v[p], fault_v[p], 3'd0};
            end
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= 8'h00;
    end else begin
      rvalid_o <= rd_en_i;
      if (rd_en_i) rdata_o <= rd_mux;
    end
  end
endmodule

// File: rtl/phy_regfile_chk.sv
module phy_regfile_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic       rd_en_i,
  input logic [3:0] addr_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_o,
  input logic       rvalid_o,
  input logic       ibr_o,
  input logic       lps_i,
  input logic       link_bit_o,
  input logic       timeout_set_i,
  input logic       ps_q,
  input logic       pwr_fail_q,
  input logic       timeout_q,
  input logic       port_event_o,
  input logic       port_evt_set
);
  p_ibr_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ibr_o |=> !ibr_o);
  p_ibr_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ibr_o) |-> $past(wr_en_i && addr_i == 4'd1 && wdata_i[6]));
  p_pwr_fail_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ps_q) |-> pwr_fail_q);
  p_evt_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(port_event_o) |-> $past(port_evt_set));
  p_link_bit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lps_i |-> !link_bit_o);
  p_set_wins_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_set_i |=> timeout_q);
  p_rvalid_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rvalid_o);
  p_caps_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && $past(addr_i) == 4'd2) |-> rdata_o == 8'hE3);
endmodule

bind phy_regfile phy_regfile_chk u_chk (
  .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i, .rdata_o, .rvalid_o,
  .ibr_o, .lps_i, .link_bit_o, .timeout_set_i,
  .ps_q (ps_q), .pwr_fail_q (pwr_fail_q), .timeout_q (timeout_q),
  .port_event_o, .port_evt_set (port_evt_set)
);

// File: tb/phy_regfile_tb_top.sv
module phy_regfile_tb_top;
  localparam int N = 3;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic wr_en = 0, rd_en = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic rvalid;
  logic [5:0] node_id = 6'h05;
  logic is_root = 1, cable_pwr = 1, lps = 0, loop_set = 0, timeout_set = 0;
  logic [2*N-1:0] astat = 0, bstat = 0;
  logic [N-1:0] child = 0, connected = 0, bias = 0, fault_set = 0, resume_start = 0;
  logic [3*N-1:0] nspeed = 0;
  logic ibr, isbr, root_hold, link_bit, contender, accel, multi, port_event;
  logic [5:0] gap;
  logic [2:0] pwr_class;
  logic [N-1:0] port_dis;

  phy_regfile #(.NPORTS(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .node_id_i(node_id),
    .is_root_i(is_root), .cable_pwr_i(cable_pwr), .lps_i(lps), .loop_set_i(loop_set),
    .timeout_set_i(timeout_set), .astat_i(astat), .bstat_i(bstat), .child_i(child),
    .connected_i(connected), .bias_i(bias), .nspeed_i(nspeed), .fault_set_i(fault_set),
    .resume_start_i(resume_start), .ibr_o(ibr), .isbr_o(isbr), .root_hold_o(root_hold),
    .gap_count_o(gap), .link_bit_o(link_bit), .contender_o(contender),
    .pwr_class_o(pwr_class), .enab_accel_o(accel), .enab_multi_o(multi),
    .port_disable_o(port_dis), .port_event_o(port_event)
  );

  int checks = 0, fails = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expectations as read data appears
  initial forever begin
    @(negedge clk);
    if (rvalid) begin
      if (exp_q.size() == 0) check(0, "R13 unexpected rvalid", rdata, 0);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(rdata == e, t, rdata, e);
      end
    end
  end

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    rd_en = 1; addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(0, "watchdog", 0, 1);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 / R2 / R5 reset state
    rd(4'h0, 8'h17, "R5 ident byte");
    rd(4'h1, 8'h3F, "R1 ctrl reset");
    rd(4'h2, 8'hE3, "R2 caps");
    rd(4'h3, 8'h40, "R2 speed");
    rd(4'h4, 8'h80, "R1 node reset");
    rd(4'h5, 8'h00, "R1 evt reset");
    rd(4'h6, 8'h00, "R2 reserved");
    rd(4'h7, 8'h00, "R1 page reset");
    // R3 command pulses
    wr(4'h1, 8'h55);
    check(ibr == 1, "R3 ibr high", ibr, 1);
    @(negedge clk);
    check(ibr == 0, "R3 ibr self-clear", ibr, 0);
    check(gap == 6'h15, "R3 gap write", gap, 6'h15);
    rd(4'h1, 8'h15, "R3 ibr reads 0");
    wr(4'h5, 8'h40);
    check(isbr == 1, "R3 isbr high", isbr, 1);
    @(negedge clk);
    check(isbr == 0, "R3 isbr self-clear", isbr, 0);
    rd(4'h5, 8'h00, "R3 isbr reads 0");
    // R8 link bit
    lps = 1; #1;
    check(link_bit == 1, "R8 link on", link_bit, 1);
    wr(4'h4, 8'h00); #1;
    check(link_bit == 0, "R8 link_active off", link_bit, 0);
    wr(4'h4, 8'h80); lps = 0; #1;
    check(link_bit == 0, "R8 lps off", link_bit, 0);
    // R9 page 0, port 1
    wr(4'h7, 8'h01);
    astat[3:2] = 2'b10; bstat[3:2] = 2'b01; child[1] = 1;
    connected[1] = 1; bias[1] = 1; nspeed[5:3] = 3'b010;
    rd(4'h8, 8'h9E, "R9 port1 status");
    rd(4'h9, 8'h40, "R9 port1 ctrl");
    rd(4'h5, 8'h00, "R6 no event when int disabled");
    // R6 change with int enabled
    wr(4'h9, 8'h10);
    @(negedge clk); bias[1] = 0;
    rd(4'h5, 8'h04, "R6 bias change sets event");
    check(port_event == 1, "R6 port_event_o", port_event, 1);
    wr(4'h5, 8'h04);
    rd(4'h5, 8'h00, "R4 port event cleared");
    // R4 write zero keeps
    @(negedge clk); loop_set = 1; @(negedge clk); loop_set = 0;
    wr(4'h5, 8'h00);
    rd(4'h5, 8'h20, "R4 loop kept on write 0");
    wr(4'h5, 8'h20);
    rd(4'h5, 8'h00, "R4 loop cleared");
    // disable write
    wr(4'h8, 8'h01);
    check(port_dis == 3'b010, "R9 port_disable_o", port_dis, 3'b010);
    rd(4'h8, 8'h9D, "R9 disabled reads back");
    rd(4'h5, 8'h04, "R6 disable change event");
    wr(4'h5, 8'h04);
    // fault
    @(negedge clk); fault_set[1] = 1; @(negedge clk); fault_set[1] = 0;
    rd(4'h9, 8'h58, "R4 fault set");
    wr(4'h5, 8'h04);
    wr(4'h9, 8'h18);
    rd(4'h9, 8'h50, "R4 fault cleared");
    rd(4'h5, 8'h04, "R6 fault clear is a change");
    wr(4'h5, 8'h04);
    // R7 resume
    @(negedge clk); resume_start[2] = 1; @(negedge clk); resume_start[2] = 0;
    rd(4'h5, 8'h00, "R7 resume ignored when disabled");
    wr(4'h5, 8'h80);
    @(negedge clk); resume_start[2] = 1; @(negedge clk); resume_start[2] = 0;
    rd(4'h5, 8'h84, "R7 resume sets event");
    wr(4'h5, 8'h84);
    rd(4'h5, 8'h80, "R7 event cleared");
    wr(4'h5, 8'h00);
    // R5 power fail
    @(negedge clk); cable_pwr = 0;
    rd(4'h5, 8'h10, "R5 power fail set");
    rd(4'h0, 8'h16, "R5 PS low");
    wr(4'h5, 8'h10);
    rd(4'h5, 8'h00, "R5 power fail cleared");
    // R12 set wins over clear
    @(negedge clk);
    wr_en = 1; addr = 4'h5; wdata = 8'h08; timeout_set = 1;
    @(negedge clk);
    wr_en = 0; timeout_set = 0;
    rd(4'h5, 8'h08, "R12 set wins");
    wr(4'h5, 8'h08);
    rd(4'h5, 8'h00, "R12 later clear");
    // R10 page 1
    wr(4'h7, 8'h20);
    rd(4'h8, 8'h01, "R10 compliance");
    rd(4'h9, 8'h00, "R10 reserved");
    rd(4'hA, 8'h12, "R10 vendor msb");
    rd(4'hB, 8'h34, "R10 vendor mid");
    rd(4'hC, 8'h56, "R10 vendor lsb");
    rd(4'hD, 8'hA5, "R10 product msb");
    rd(4'hE, 8'h5A, "R10 product mid");
    rd(4'hF, 8'hC3, "R10 product lsb");
    // R11 unimplemented areas
    wr(4'h7, 8'h40);
    rd(4'h8, 8'h00, "R11 page 2");
    wr(4'h7, 8'h03);
    rd(4'h8, 8'h00, "R11 port 3 read");
    wr(4'h8, 8'h01);
    check(port_dis == 3'b010, "R11 port 3 write ignored", port_dis, 3'b010);
    wr(4'h7, 8'h01);
    rd(4'hA, 8'h00, "R11 page0 reserved addr");
    wr(4'h6, 8'hFF);
    rd(4'h6, 8'h00, "R11 reserved write");
    wr(4'h7, 8'h35);
    rd(4'h7, 8'h25, "R9 page byte bit 4 zero");
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R13 all reads answered", exp_q.size(), 0);
    done = 1;
    finish_run();
  end
endmodule